// File: doc/BRIEF.md
# Command/Indication Channel Controller

This block serves the two command/indication fields of a time-division-multiplexed serial frame. A frame-sync pulse and a bit strobe mark the frame structure. On the receive line the block picks a 4-bit primary code and a 6-bit secondary code out of fixed frame positions, checks each for a change and raises a sticky change flag. On the transmit line it sends the codes held in two host-written registers in the same positions, and holds the line high everywhere else.

The primary code goes through a two-frame filter. A new value is taken only after it has been seen in two frames in a row, so a single corrupted frame cannot reach the host. The secondary code has no filter and is taken on the first frame in which it differs. The secondary field is only used while the terminal-mode input is high. A small register port lets the host read the accepted codes and the flags, write the transmit codes and write a two-bit interrupt enable.

Top module: `cic_ctrl`

## Requirements
- R1: After reset both receive codes read all ones (0x0F primary, 0x3F secondary), the status/enable word reads 0, `irq` is low and `txd` is high.
- R2: In every frame, `txd` carries the primary transmit code in frame bits 26..29, most significant bit in bit 26. Frame bit 0 is the strobe that comes with `fsync`. Each bit is driven from the clock after its strobe until the next strobe.
- R3: While `term_mode` is high, `txd` carries the secondary transmit code in frame bits 58..63, MSB first. While `term_mode` is low, those bits are high.
- R4: Every frame bit outside the active fields is driven high on `txd`.
- R5: The primary receive code, sampled MSB first from bits 26..29, is accepted only when the same new value arrives in two consecutive frames. On acceptance the receive register updates and status bit 0 is set. A value equal to the accepted code changes nothing.
- R6: A new primary value seen in one frame, followed by a frame carrying the accepted code, is dropped and leaves no pending state. A following frame with that value therefore counts as the first of two.
- R7: A secondary value from bits 58..63 that differs from the accepted one updates the register and sets status bit 1 at the end of that same frame.
- R8: While `term_mode` is low, the secondary field is not sampled and status bit 1 is never set.
- R9: Status bits are sticky. Reading address 0 clears bit 0 and reading address 1 clears bit 1. A change arriving in the same cycle as the read wins over the clear.
- R10: `irq` is the registered OR of the status bits masked by the enable bits. It follows the status one cycle later.
- R11: Register map (`reg_rdata` is valid the cycle after `reg_rd`):
  - Address 0: reads the primary code in [3:0]; a write sets the primary transmit code from [3:0].
  - Address 1: reads the secondary code in [5:0]; a write sets the secondary transmit code from [5:0].
  - Address 2: reads status in [1:0] and enable in [3:2]; a write sets enable from [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame start, high together with the bit strobe of frame bit 0 |
| bit_stb | input | 1 | One-cycle strobe per serial bit |
| rxd | input | 1 | Serial receive data, sampled on `bit_stb` |
| term_mode | input | 1 | Enables the secondary field |
| txd | output | 1 | Serial transmit data, registered |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- the bit after the primary field start strobe carries the transmit MSB;
- bits outside the active fields are high;
- the accepted primary code changes only at the strobe that ends its field;
- a read clears the matching flag unless a change arrives with it;
- `term_mode` low blocks the secondary flag;
- `irq` tracks the masked status one cycle later.

Only the bench's frame sequences can show the code contents over whole frames:
- the two-frame filter, including a glitch frame followed by a return to the old code;
- immediate secondary acceptance;
- the register map contents.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [1:0] {
    RA_PRI = 2'd0,
    RA_SEC = 2'd1,
    RA_CTL = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/cic_frame_timer.sv
module cic_frame_timer #(
  parameter int FRAME_BITS = 96,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_stb,
  input  logic          fsync,
  output logic [IW-1:0] bit_idx
);
  localparam logic [IW-1:0] LAST_I = IW'(FRAME_BITS - 1);

  logic [IW-1:0] cnt_q;

  // index of the bit that the current strobe belongs to
  assign bit_idx = fsync ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (bit_stb) begin
      cnt_q <= (bit_idx == LAST_I) ? '0 : bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/cic_field_rx.sv
module cic_field_rx #(
  parameter int W = 4,
  parameter int LAST_BIT = 29,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_stb,
  input  logic          rxd,
  input  logic          en,
  input  logic [IW-1:0] bit_idx,
  output logic [W-1:0]  cand,
  output logic          done
);
  localparam logic [IW-1:0] LAST_I = IW'(LAST_BIT);

  logic [W-2:0] sh_q;

  assign cand = {sh_q, rxd};
  assign done = bit_stb & en & (bit_idx == LAST_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '1;
    end else if (bit_stb) begin
      sh_q <= cand[W-2:0];
    end
  end
endmodule

// File: rtl/cic_code_filter.sv
module cic_code_filter #(
  parameter int W = 4,
  parameter bit DOUBLE_LOOK = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done,
  input  logic [W-1:0] cand,
  output logic [W-1:0] code_q,
  output logic         chg_q
);
  generate
    if (DOUBLE_LOOK) begin : g_dll
      logic [W-1:0] pend_q;
      logic         pend_v_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          code_q   <= '1;
          chg_q    <= 1'b0;
          pend_q   <= '1;
          pend_v_q <= 1'b0;
        end else begin
          chg_q <= 1'b0;
          if (done) begin
            if (cand == code_q) begin
              pend_v_q <= 1'b0;
            end else if (pend_v_q && (cand == pend_q)) begin
              code_q   <= cand;
              chg_q    <= 1'b1;
              pend_v_q <= 1'b0;
            end else begin
              pend_q   <= cand;
              pend_v_q <= 1'b1;
            end
          end
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          code_q <= '1;
          chg_q  <= 1'b0;
        end else begin
          chg_q <= 1'b0;
          if (done && (cand != code_q)) begin
            code_q <= cand;
            chg_q  <= 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cic_tx_mux.sv
module cic_tx_mux #(
  parameter int P_POS = 26,
  parameter int P_W = 4,
  parameter int S_POS = 58,
  parameter int S_W = 6,
  parameter int IW = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_stb,
  input  logic           term_mode,
  input  logic [IW-1:0]  bit_idx,
  input  logic [P_W-1:0] cix0,
  input  logic [S_W-1:0] cix1,
  output logic           txd
);
  logic nxt;

  always_comb begin
    nxt = 1'b1;
    for (int k = 0; k < P_W; k++) begin
      if (bit_idx == IW'(P_POS + P_W - 1 - k)) nxt = cix0[k];
    end
    for (int k = 0; k < S_W; k++) begin
      if (term_mode && (bit_idx == IW'(S_POS + S_W - 1 - k))) nxt = cix1[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd <= 1'b1;
    end else if (bit_stb) begin
      txd <= nxt;
    end
  end
endmodule

// File: rtl/cic_regs.sv
module cic_regs
  import cic_pkg::*;
#(
  parameter int P_W = 4,
  parameter int S_W = 6,
  parameter int DW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [P_W-1:0] code0,
  input  logic [S_W-1:0] code1,
  input  logic           chg0,
  input  logic           chg1,
  output logic [P_W-1:0] cix0_q,
  output logic [S_W-1:0] cix1_q,
  output logic [1:0]     stat_q,
  output logic [1:0]     en_q,
  output logic           irq
);
  logic rd_pri, rd_sec;

  assign rd_pri = reg_rd && (reg_addr == RA_PRI);
  assign rd_sec = reg_rd && (reg_addr == RA_SEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      cix0_q    <= '1;
      cix1_q    <= '1;
      en_q      <= '0;
      stat_q    <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_PRI:  cix0_q <= reg_wdata[P_W-1:0];
          RA_SEC:  cix1_q <= reg_wdata[S_W-1:0];
          RA_CTL:  en_q   <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          RA_PRI:  reg_rdata <= DW'(code0);
          RA_SEC:  reg_rdata <= DW'(code1);
          RA_CTL:  reg_rdata <= DW'({en_q, stat_q});
          default: reg_rdata <= '0;
        endcase
      end
      stat_q[0] <= chg0 | (stat_q[0] & ~rd_pri);
      stat_q[1] <= chg1 | (stat_q[1] & ~rd_sec);
      irq       <= |(stat_q & en_q);
    end
  end
endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl #(
  parameter int FRAME_BITS = 96,
  parameter int P_POS = 26,
  parameter int P_W = 4,
  parameter int S_POS = 58,
  parameter int S_W = 6,
  localparam int DW = S_W,
  localparam int IW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  input  logic          bit_stb,
  input  logic          rxd,
  input  logic          term_mode,
  output logic          txd,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [IW-1:0]  bit_idx;
  logic [P_W-1:0] p_cand, cir0_q, cix0_q;
  logic [S_W-1:0] s_cand, cir1_q, cix1_q;
  logic           p_done, s_done, p_chg, s_chg;
  logic [1:0]     stat_q, en_q;

  cic_frame_timer #(.FRAME_BITS(FRAME_BITS), .IW(IW)) timer_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .fsync(fsync), .bit_idx(bit_idx)
  );

  cic_field_rx #(.W(P_W), .LAST_BIT(P_POS + P_W - 1), .IW(IW)) prx_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .rxd(rxd), .en(1'b1),
    .bit_idx(bit_idx), .cand(p_cand), .done(p_done)
  );

  cic_field_rx #(.W(S_W), .LAST_BIT(S_POS + S_W - 1), .IW(IW)) srx_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .rxd(rxd), .en(term_mode),
    .bit_idx(bit_idx), .cand(s_cand), .done(s_done)
  );

  cic_code_filter #(.W(P_W), .DOUBLE_LOOK(1'b1)) pflt_i (
    .clk(clk), .rst(rst), .done(p_done), .cand(p_cand),
    .code_q(cir0_q), .chg_q(p_chg)
  );

  cic_code_filter #(.W(S_W), .DOUBLE_LOOK(1'b0)) sflt_i (
    .clk(clk), .rst(rst), .done(s_done), .cand(s_cand),
    .code_q(cir1_q), .chg_q(s_chg)
  );

  cic_tx_mux #(.P_POS(P_POS), .P_W(P_W), .S_POS(S_POS), .S_W(S_W), .IW(IW)) tx_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .term_mode(term_mode),
    .bit_idx(bit_idx), .cix0(cix0_q), .cix1(cix1_q), .txd(txd)
  );

  cic_regs #(.P_W(P_W), .S_W(S_W), .DW(DW)) regs_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .code0(cir0_q), .code1(cir1_q),
    .chg0(p_chg), .chg1(s_chg), .cix0_q(cix0_q), .cix1_q(cix1_q),
    .stat_q(stat_q), .en_q(en_q), .irq(irq)
  );
endmodule

// File: rtl/cic_ctrl_chk.sv
module cic_ctrl_chk #(
  parameter int P_POS = 26,
  parameter int P_W = 4,
  parameter int S_POS = 58,
  parameter int S_W = 6,
  parameter int IW = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           bit_stb,
  input logic           term_mode,
  input logic           txd,
  input logic           irq,
  input logic           reg_rd,
  input logic [1:0]     reg_addr,
  input logic [IW-1:0]  bit_idx,
  input logic [P_W-1:0] cix0_q,
  input logic [P_W-1:0] cir0_q,
  input logic [1:0]     stat_q,
  input logic [1:0]     en_q,
  input logic           p_chg
);
  localparam logic [IW-1:0] P_FIRST = IW'(P_POS);
  localparam logic [IW-1:0] P_LAST  = IW'(P_POS + P_W - 1);
  localparam logic [IW-1:0] S_FIRST = IW'(S_POS);
  localparam logic [IW-1:0] S_LAST  = IW'(S_POS + S_W - 1);

  logic in_fld;
  assign in_fld = ((bit_idx >= P_FIRST) && (bit_idx <= P_LAST)) ||
                  (term_mode && (bit_idx >= S_FIRST) && (bit_idx <= S_LAST));

  a_r2_primary_msb: assert property (@(posedge clk) disable iff (rst)
    $past(bit_stb && (bit_idx == P_FIRST)) |-> (txd == $past(cix0_q[P_W-1])));

  a_r4_idle_high: assert property (@(posedge clk) disable iff (rst)
    $past(bit_stb && !in_fld) |-> txd);

  a_r5_update_at_field_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(cir0_q) |-> $past(bit_stb && (bit_idx == P_LAST)));

  a_r8_no_sec_flag: assert property (@(posedge clk) disable iff (rst)
    !term_mode |=> !$rose(stat_q[1]));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && (reg_addr == 2'd0) && !p_chg) |-> !stat_q[0]);

  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(stat_q & en_q)));
endmodule

bind cic_ctrl cic_ctrl_chk #(
  .P_POS(P_POS), .P_W(P_W), .S_POS(S_POS), .S_W(S_W), .IW(IW)
) chk_i (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .term_mode(term_mode), .txd(txd),
  .irq(irq), .reg_rd(reg_rd), .reg_addr(reg_addr), .bit_idx(bit_idx),
  .cix0_q(cix0_q), .cir0_q(cir0_q), .stat_q(stat_q), .en_q(en_q), .p_chg(p_chg)
);

// File: tb/cic_ctrl_tb_top.sv
`timescale 1ns/1ps
module cic_ctrl_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, fsync = 1'b0, bit_stb = 1'b0, rxd = 1'b1, term_mode = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic       txd, irq;

  cic_ctrl dut_i (
    .clk(clk), .rst(rst), .fsync(fsync), .bit_stb(bit_stb), .rxd(rxd),
    .term_mode(term_mode), .txd(txd), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model
  logic [3:0]  m_cir0 = 4'hF, m_pend = 4'hF, m_cix0 = 4'hF;
  logic        m_pv = 1'b0;
  logic [5:0]  m_cir1 = 6'h3F, m_cix1 = 6'h3F;
  logic [1:0]  m_st = 2'b00, m_en = 2'b00;
  logic [95:0] txcap;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    if (a == 2'd0) m_cix0 = d[3:0];
    else if (a == 2'd1) m_cix1 = d;
    else if (a == 2'd2) m_en = d[1:0];
  endtask

  task automatic rd_chk(input logic [1:0] a, input string tag);
    int exp;
    exp = (a == 2'd0) ? int'(m_cir0) : (a == 2'd1) ? int'(m_cir1) : int'({m_en, m_st});
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    chk(tag, int'(reg_rdata), exp);
    if (a == 2'd0) m_st[0] = 1'b0;
    if (a == 2'd1) m_st[1] = 1'b0;
  endtask

  task automatic irq_chk(input string tag);
    repeat (3) @(negedge clk);
    chk(tag, int'(irq), int'(|(m_st & m_en)));
  endtask

  function automatic logic rx_bit(input int b, input logic [3:0] p, input logic [5:0] s);
    if (b >= 26 && b <= 29) return p[29 - b];
    if (b >= 58 && b <= 63) return s[63 - b];
    return 1'($urandom % 2);
  endfunction

  task automatic frame(input logic [3:0] p, input logic [5:0] s, input logic tm);
    logic [3:0] ap;
    logic [5:0] as_, es;
    int bad;
    term_mode = tm;
    for (int b = 0; b < 96; b++) begin
      @(negedge clk); fsync = (b == 0); bit_stb = 1'b1; rxd = rx_bit(b, p, s);
      @(negedge clk); fsync = 1'b0; bit_stb = 1'b0;
      @(negedge clk); txcap[b] = txd;
    end
    // model update
    if (p == m_cir0) m_pv = 1'b0;
    else if (m_pv && p == m_pend) begin m_cir0 = p; m_st[0] = 1'b1; m_pv = 1'b0; end
    else begin m_pend = p; m_pv = 1'b1; end
    if (tm && s != m_cir1) begin m_cir1 = s; m_st[1] = 1'b1; end
    // transmit checks
    ap  = {txcap[26], txcap[27], txcap[28], txcap[29]};
    as_ = {txcap[58], txcap[59], txcap[60], txcap[61], txcap[62], txcap[63]};
    es  = tm ? m_cix1 : 6'h3F;
    chk("R2 primary tx field", int'(ap), int'(m_cix0));
    chk("R3 secondary tx field", int'(as_), int'(es));
    bad = 0;
    for (int b = 0; b < 96; b++)
      if (!((b >= 26 && b <= 29) || (b >= 58 && b <= 63)) && txcap[b] !== 1'b1) bad++;
    chk("R4 idle bits high", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] last_p;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd idle after reset", int'(txd), 1);
    chk("R1 irq low after reset", int'(irq), 0);
    rd_chk(2'd0, "R1 primary rx reset ones");
    rd_chk(2'd1, "R1 secondary rx reset ones");
    rd_chk(2'd2, "R1 status clear after reset");

    wr(2'd2, 6'b000011);
    rd_chk(2'd2, "R11 enable readback");
    frame(4'hF, 6'h3F, 1'b1);
    rd_chk(2'd2, "R5 same code no flag");

    wr(2'd0, 6'h0A);
    wr(2'd1, 6'h15);
    frame(4'hF, 6'h3F, 1'b1);

    // two-frame acceptance
    frame(4'h5, 6'h3F, 1'b1);
    rd_chk(2'd2, "R5 one frame not accepted");
    frame(4'h5, 6'h3F, 1'b1);
    rd_chk(2'd2, "R5 status after second frame");
    irq_chk("R10 irq raised");
    rd_chk(2'd0, "R5 primary code accepted");
    rd_chk(2'd2, "R9 read cleared primary flag");
    irq_chk("R10 irq dropped");

    // glitch then return
    frame(4'h9, 6'h3F, 1'b1);
    frame(4'h5, 6'h3F, 1'b1);
    frame(4'h9, 6'h3F, 1'b1);
    rd_chk(2'd0, "R6 glitch dropped");
    rd_chk(2'd2, "R6 no flag after glitch");
    frame(4'h9, 6'h3F, 1'b1);
    rd_chk(2'd0, "R6 accepted after two");

    // secondary
    frame(4'h9, 6'h2A, 1'b1);
    rd_chk(2'd2, "R7 secondary flag at once");
    rd_chk(2'd1, "R7 secondary code");
    frame(4'h9, 6'h11, 1'b0);
    rd_chk(2'd2, "R8 no secondary flag off mode");
    rd_chk(2'd1, "R8 secondary unchanged off mode");

    // enable masking
    wr(2'd2, 6'b000010);
    frame(4'h3, 6'h2A, 1'b1);
    frame(4'h3, 6'h2A, 1'b1);
    irq_chk("R10 masked flag no irq");
    rd_chk(2'd2, "R9 flag sticky under mask");

    // random frames
    last_p = m_cir0;
    for (int i = 0; i < 50; i++) begin
      logic [3:0] p;
      logic [5:0] s;
      logic tm;
      int r;
      r = int'($urandom % 4);
      p = (r == 0) ? last_p : (r == 1) ? m_cir0 : 4'($urandom);
      s = ($urandom % 2) ? m_cir1 : 6'($urandom);
      tm = ($urandom % 4) != 0;
      if ($urandom % 4 == 0) wr(2'($urandom % 3), 6'($urandom));
      frame(p, s, tm);
      last_p = p;
      irq_chk("R10 random irq");
      if ($urandom % 2) rd_chk(2'd0, "R5 random primary read");
      if ($urandom % 2) rd_chk(2'd1, "R7 random secondary read");
      rd_chk(2'd2, "R9 random status");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule